// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the address that a synchronous burst memory applies to its array in each cycle. Either of two start strobes captures an external address. One strobe is driven by the processor side and the other by the memory controller side. After that capture, the two least significant address bits step through a four-entry burst, one step per cycle in which the advance input is high. The upper address bits stay as they were captured.

A static order input chooses between two counting rules. Interleaved order forms the low bits as the start offset XOR a beat count. Linear order adds the beat count to the start offset and wraps modulo four. Tying the order input low gives interleaved order, which is the default.

Bursting is optional. A fresh address may be captured on every cycle with no idle cycle between captures. The block also reports the current beat number (0 to 3) so that downstream logic can track where it is inside a burst.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is active and right after it is released, `cur_addr` is all zeros and `beat` is 0.
- R2: If `strb_cpu` and `cen` are both high at a rising edge, `ld_addr` is captured. After that edge, `cur_addr` equals `ld_addr` and `beat` is 0. This capture takes priority over `adv`.
- R3: If `strb_ctl` and `cen` are both high at a rising edge, `ld_addr` is captured in the same way as in R2.
- R4: With `cen` low, both strobes have no effect. `cur_addr` and `beat` behave exactly as they would with no strobe present.
- R5: If both strobes are high together with `cen`, one capture takes place, selected in favour of the processor-side strobe. Afterwards `cur_addr` equals `ld_addr` and `beat` is 0.
- R6: In a cycle with no capture and `adv` high, `beat` increases by one modulo 4. The bits of `cur_addr` above bit 1 do not change.
- R7: In a cycle with no capture and `adv` low, `cur_addr` and `beat` keep their values (burst suspend).
- R8: When `order_lin` is 0 (interleaved), `cur_addr[1:0]` equals the captured start offset XOR `beat`.
- R9: When `order_lin` is 1 (linear), `cur_addr[1:0]` equals (captured start offset + `beat`) mod 4.
- R10: After four advances, the burst wraps back to the start offset with `beat` equal to 0.
- R11: Captures on consecutive cycles each take effect on the following edge, with no lost cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cen | input | 1 | Chip enable, active high; qualifies both strobes |
| strb_cpu | input | 1 | Processor-side burst start strobe |
| strb_ctl | input | 1 | Controller-side burst start strobe |
| adv | input | 1 | Step the burst by one beat |
| order_lin | input | 1 | 1 = linear order, 0 = interleaved order |
| ld_addr | input | ADDR_W | External address to capture |
| cur_addr | output | ADDR_W | Address currently presented to the array |
| beat | output | 2 | Beat number within the current burst |

## Verification
The case that is hardest to reach from the ports is a suspended burst that later resumes and wraps. Reaching it needs a capture, then an uneven mix of advance and idle cycles with no stray strobe that has `cen` high, and it must be seen under both counting orders and from every start offset. Random stimulus alone seldom produces it, because captures are frequent. The bench therefore runs directed walks that cover all four offsets in both orders, including suspend cycles and a full wrap. It then runs random phases with a low capture probability and a fixed order within each phase, so that long bursts with suspends occur often.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int BEAT_W = 2;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_CPU  = 2'd1,
    SRC_CTL  = 2'd2
  } load_src_e;

  // Low address bits for a given start offset and beat count.
  function automatic logic [BEAT_W-1:0] beat_offset(
    input logic [BEAT_W-1:0] start,
    input logic [BEAT_W-1:0] cnt,
    input logic              lin
  );
    logic [BEAT_W-1:0] res;
    if (lin) res = start + cnt;
    else     res = start ^ cnt;
    return res;
  endfunction
endpackage

// File: rtl/burst_start_arb.sv
module burst_start_arb
  import burst_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cen,
  input  logic      strb_cpu,
  input  logic      strb_ctl,
  output logic      load_now,
  output load_src_e load_src
);
  logic sel_cpu;
  logic sel_ctl;

  assign sel_cpu  = strb_cpu & cen;
  assign sel_ctl  = strb_ctl & cen & ~sel_cpu;
  assign load_now = sel_cpu | sel_ctl;

  always_comb begin
    if (sel_cpu)      load_src = SRC_CPU;
    else if (sel_ctl) load_src = SRC_CTL;
    else              load_src = SRC_NONE;
  end

  // R5: at most one source is selected in any cycle
  a_r5_one_source: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_cpu, sel_ctl}));

  // R4: no capture without chip enable
  a_r4_cen_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !cen |-> (load_src == SRC_NONE));
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_now,
  input  logic              adv,
  output logic [BEAT_W-1:0] cnt
);
  logic [BEAT_W-1:0] cnt_next;

  always_comb begin
    cnt_next = cnt;
    if (load_now) cnt_next = '0;
    else if (adv) cnt_next = cnt + BEAT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_next;
  end

  a_r2_load_clears_beat: assert property (@(posedge clk) disable iff (!rst_n)
    load_now |=> (cnt == '0));

  a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_now && adv) |=> (cnt == $past(cnt) + BEAT_W'(1)));

  a_r7_suspend: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_now && !adv) |=> $stable(cnt));
endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg #(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_now,
  input  logic [ADDR_W-1:0] ld_addr,
  output logic [ADDR_W-1:0] base
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        base <= '0;
    else if (load_now) base <= ld_addr;
  end

  a_r6_base_held: assert property (@(posedge clk) disable iff (!rst_n)
    !load_now |=> $stable(base));

  a_r11_base_taken: assert property (@(posedge clk) disable iff (!rst_n)
    load_now |=> (base == $past(ld_addr)));
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cen,
  input  logic              strb_cpu,
  input  logic              strb_ctl,
  input  logic              adv,
  input  logic              order_lin,
  input  logic [ADDR_W-1:0] ld_addr,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [1:0]        beat
);
  localparam int HI_W = ADDR_W - BEAT_W;

  logic              load_now;
  load_src_e         load_src;
  logic [BEAT_W-1:0] cnt;
  logic [ADDR_W-1:0] base;
  logic [BEAT_W-1:0] low_bits;

  burst_start_arb u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .cen      (cen),
    .strb_cpu (strb_cpu),
    .strb_ctl (strb_ctl),
    .load_now (load_now),
    .load_src (load_src)
  );

  burst_beat_ctr u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_now (load_now),
    .adv      (adv),
    .cnt      (cnt)
  );

  burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_now (load_now),
    .ld_addr  (ld_addr),
    .base     (base)
  );

  assign low_bits = beat_offset(base[BEAT_W-1:0], cnt, order_lin);
  assign cur_addr = {base[ADDR_W-1:BEAT_W], low_bits};
  assign beat     = cnt;

  // R10: at beat 0 the array sees the start offset in either order
  a_r10_wrap_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) |-> (cur_addr[BEAT_W-1:0] == base[BEAT_W-1:0]));

  a_r6_upper_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (load_src == SRC_NONE) |=> (cur_addr[ADDR_W-1:BEAT_W] == $past(cur_addr[ADDR_W-1:BEAT_W])));

  a_r7_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_now && !adv && $stable(order_lin)) |=> ($stable(cur_addr) || !$stable(order_lin)));

  initial begin
    a_r1_width: assert (HI_W >= 1);
  end
endmodule

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cen = 1'b0;
  logic          strb_cpu = 1'b0;
  logic          strb_ctl = 1'b0;
  logic          adv = 1'b0;
  logic          order_lin = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [AW-1:0] cur_addr;
  logic [1:0]    beat;

  int n_tests = 0;
  int n_fail  = 0;

  logic [AW-1:0] m_base = '0;
  int            m_cnt  = 0;
  string         tag    = "R1";

  always #5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cen(cen), .strb_cpu(strb_cpu),
    .strb_ctl(strb_ctl), .adv(adv), .order_lin(order_lin),
    .ld_addr(ld_addr), .cur_addr(cur_addr), .beat(beat)
  );

  function automatic logic [AW-1:0] exp_addr(logic [AW-1:0] b, int c, logic lin);
    int s;
    int lo;
    s = int'(b[1:0]);
    if (lin) lo = (s + c) % 4;
    else     lo = s ^ c;
    return {b[AW-1:2], 2'(lo)};
  endfunction

  task automatic check_now();
    logic [AW-1:0] ea;
    ea = exp_addr(m_base, m_cnt, order_lin);
    n_tests++;
    if (cur_addr !== ea || beat !== 2'(m_cnt)) begin
      n_fail++;
      $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
               tag, cur_addr, beat, ea, m_cnt);
    end
  endtask

  // Drive one cycle of inputs at the falling edge, update the model,
  // then check after the next rising edge.
  task automatic step(logic c, logic sp, logic sc, logic a,
                      logic [AW-1:0] la, string t);
    cen = c; strb_cpu = sp; strb_ctl = sc; adv = a; ld_addr = la;
    tag = t;
    if (c && (sp || sc)) begin
      m_base = la; m_cnt = 0;
    end else if (a) begin
      m_cnt = (m_cnt + 1) % 4;
    end
    @(negedge clk);
    check_now();
  endtask

  initial begin
    #1500000;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    @(negedge clk);
    tag = "R1"; check_now();
    @(negedge clk);
    rst_n = 1'b1;
    tag = "R1"; check_now();

    // R2 and R8: interleaved walk from every offset, with suspends (R7)
    order_lin = 1'b0;
    for (int off = 0; off < 4; off++) begin
      step(1, 1, 0, 1, {18'h2A5C3, 2'(off)}, "R2");
      step(1, 0, 0, 1, '0, "R8");
      step(0, 0, 0, 0, '0, "R7");
      step(0, 0, 0, 1, '0, "R8");
      step(0, 0, 0, 1, '0, "R8");
      step(0, 0, 0, 1, '0, "R10");
    end
    // R3 and R9: linear walk
    order_lin = 1'b1;
    for (int off = 0; off < 4; off++) begin
      step(1, 0, 1, 0, {18'h1F00E, 2'(off)}, "R3");
      step(0, 0, 0, 1, '0, "R9");
      step(1, 0, 0, 0, '0, "R7");
      step(1, 0, 0, 1, '0, "R9");
      step(0, 0, 0, 1, '0, "R9");
      step(0, 0, 0, 1, '0, "R10");
    end
    // R4: strobes without chip enable have no effect
    step(0, 1, 0, 0, 20'hFFFFF, "R4");
    step(0, 0, 1, 1, 20'h12345, "R4");
    step(0, 1, 1, 0, 20'h0AAAA, "R4");
    // R5: both strobes together
    step(1, 1, 1, 1, 20'h54321, "R5");
    step(1, 1, 1, 0, 20'h00003, "R5");
    // R11: back-to-back captures
    for (int i = 0; i < 6; i++)
      step(1, i[0], ~i[0], 1, 20'(32'h3C001 + i * 32'h1111), "R11");

    // Random phases, order fixed per phase
    for (int ph = 0; ph < 20; ph++) begin
      order_lin = ph[0];
      for (int k = 0; k < 300; k++) begin
        logic c, sp, sc, a;
        c  = ($urandom % 4) != 0;
        sp = ($urandom % 10) == 0;
        sc = ($urandom % 10) == 0;
        a  = ($urandom % 3) != 0;
        step(c, sp, sc, a, 20'($urandom),
             (c && (sp || sc)) ? "R2" : (a ? (ph[0] ? "R9" : "R8") : "R7"));
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule